// File: doc/BRIEF.md
# 16-bit Arithmetic and Test Unit with Overflow Word

This unit computes the value half of a small 16-bit processor's two-operand instructions. Each cycle it may take one operation code and two word operands. One clock later it presents the 16-bit result together with its write enable, a replacement value for the processor's overflow word with its own write enable, and a condition flag for the four test instructions. The surrounding core fetches the operands, writes the results back and decides whether to skip the next instruction. None of that is inside this block.

The overflow word does not hold a single carry bit. Its new value depends on the operation:

- a carry indication for addition;
- an all-ones borrow mask for subtraction;
- the upper half of the product for multiplication;
- the binary fraction of the quotient for division;
- the bits pushed out by a shift.

Division and remainder by zero return defined zero values. Shift amounts of twice the word width or more flush both outputs to zero.

Top module: `wordalu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge leaves `out_valid`, `out_res_we`, `out_o_we` and `out_cond` all at 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and all other outputs belong to the operation accepted on that same edge. Operation codes are 0 none, 1 copy, 2 add, 3 subtract, 4 multiply, 5 divide, 6 remainder, 7 shift left, 8 shift right, 9 and, 10 or, 11 exclusive-or, 12 equal, 13 not-equal, 14 greater, 15 any-common-bit.
- R3: Copy (1) writes `b` as the result and does not write the overflow word.
- R4: Add (2) writes the low 16 bits of a+b and sets the overflow word to 0x0001 when the unsigned sum exceeds 0xffff, else 0x0000.
- R5: Subtract (3) writes the low 16 bits of a-b and sets the overflow word to 0xffff when b > a (unsigned), else 0x0000.
- R6: Multiply (4) writes the low half of the 32-bit product and sets the overflow word to its upper half.
- R7: Divide (5) writes the unsigned quotient a/b and sets the overflow word to the low 16 bits of (a*65536)/b. When b is 0, both values are 0.
- R8: Remainder (6) writes a mod b, or 0 when b is 0, and does not write the overflow word.
- R9: Shift left (7) writes the low 16 bits of a shifted left by b and sets the overflow word to bits 31..16 of that shift. Shift right (8) writes a shifted right by b and sets the overflow word to the low 16 bits of (a*65536) shifted right by b. For b of 32 or more, both values are 0.
- R10: And (9), or (10) and exclusive-or (11) write the bitwise result and do not write the overflow word.
- R11: Tests 12 to 15 write neither result nor overflow word. `out_cond` is 1 when, respectively, a==b, a!=b, a>b unsigned, or (a&b)!=0.
- R12: Code 0 writes nothing and gives `out_cond` 0. Every operation other than a test also gives `out_cond` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 16 | First operand (destination value) |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Outputs below belong to a valid operation |
| out_result | output | 16 | Result word |
| out_res_we | output | 1 | Result should be written back |
| out_o_we | output | 1 | Overflow word should be replaced |
| out_o_val | output | 16 | New overflow word value |
| out_cond | output | 1 | Test outcome for codes 12 to 15 |

## Verification
The bench builds the unit with the default word width of 16. At that width, hand-picked operands can reach every arithmetic boundary: full-range carries and borrows, the 0xffff squared product, a divisor of zero, and shift amounts on both sides of 32, including the largest possible amount of 0xffff. Random operand pairs for every code then cover the general case, and idle cycles placed between operations check that the one-cycle valid timing holds across gaps.

// File: rtl/wordalu_pkg.sv
// Package: operation codes shared by the unit, its checker and any user.
// Assumes a 4-bit code field; all sixteen values are named.
package wordalu_pkg;

    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_NONE = 4'h0,
        OP_COPY = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_MUL  = 4'h4,
        OP_DIV  = 4'h5,
        OP_REM  = 4'h6,
        OP_SHL  = 4'h7,
        OP_SHR  = 4'h8,
        OP_AND  = 4'h9,
        OP_OR   = 4'hA,
        OP_XOR  = 4'hB,
        OP_TEQ  = 4'hC,
        OP_TNE  = 4'hD,
        OP_TGT  = 4'hE,
        OP_TANY = 4'hF
    } wordalu_op_e;

endpackage

// File: rtl/wordalu_arith.sv
// Module: add, subtract and multiply datapath with overflow-word values.
// Purely combinational. Assumes unsigned operands of W bits.
module wordalu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi
);
    localparam int PW = 2 * W;

    logic [W:0]    sum_w;
    logic [W:0]    diff_w;
    logic [PW-1:0] prod_w;

    // Widened sum, difference and product; the extra bits become O.
    always_comb begin
        sum_w   = {1'b0, a} + {1'b0, b};
        diff_w  = {1'b0, a} - {1'b0, b};
        prod_w  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        sum     = sum_w[W-1:0];
        sum_o   = {{(W-1){1'b0}}, sum_w[W]};
        diff    = diff_w[W-1:0];
        diff_o  = {W{diff_w[W]}};
        prod_lo = prod_w[W-1:0];
        prod_hi = prod_w[PW-1:W];
    end
endmodule

// File: rtl/wordalu_divmod.sv
// Module: unsigned quotient, fractional quotient and remainder.
// Combinational. A zero divisor forces all three outputs to zero.
module wordalu_divmod #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic [W-1:0] frac,
    output logic [W-1:0] rem
);
    localparam int DW = 2 * W;

    logic [DW-1:0] frac_w;

    // Divide with a zero-divisor guard; the fraction divides a shifted numerator.
    always_comb begin
        quot   = '0;
        frac   = '0;
        rem    = '0;
        frac_w = '0;
        if (b != '0) begin
            quot   = a / b;
            rem    = a % b;
            frac_w = {a, {W{1'b0}}} / {{W{1'b0}}, b};
            frac   = frac_w[W-1:0];
        end
    end
endmodule

// File: rtl/wordalu_shift.sv
// Module: logical shifts in both directions through a double-width window.
// Combinational. Amounts of 2*W or more flush both halves to zero.
module wordalu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    output logic [W-1:0] shl_res,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_res,
    output logic [W-1:0] shr_o
);
    localparam int SW  = 2 * W;
    localparam int AMB = $clog2(SW);

    logic [SW-1:0]  left_w;
    logic [SW-1:0]  right_w;
    logic [AMB-1:0] amt_s;
    logic           flush;

    // Place the operand low (left shift) or high (right shift), then shift.
    always_comb begin
        flush   = (amt >= W'(SW));
        amt_s   = amt[AMB-1:0];
        left_w  = '0;
        right_w = '0;
        if (!flush) begin
            left_w  = {{W{1'b0}}, a} << amt_s;
            right_w = {a, {W{1'b0}}} >> amt_s;
        end
        shl_res = left_w[W-1:0];
        shl_o   = left_w[SW-1:W];
        shr_res = right_w[SW-1:W];
        shr_o   = right_w[W-1:0];
    end
endmodule

// File: rtl/wordalu_cmp.sv
// Module: the four test predicates on two unsigned words.
// Combinational; exactly the predicate picked by the top is used.
module wordalu_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         t_eq,
    output logic         t_ne,
    output logic         t_gt,
    output logic         t_any
);
    // Evaluate every predicate in parallel.
    always_comb begin
        t_eq  = (a == b);
        t_ne  = (a != b);
        t_gt  = (a > b);
        t_any = |(a & b);
    end
endmodule

// File: rtl/wordalu.sv
// Module: top of the word arithmetic unit. It selects one datapath result
// per operation code and registers it once, so results appear one clock
// after acceptance. Assumes the caller holds operands stable only for the
// accepting cycle; reset is synchronous and active low.
module wordalu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_res_we,
    output logic         out_o_we,
    output logic [W-1:0] out_o_val,
    output logic         out_cond
);
    import wordalu_pkg::*;

    logic [W-1:0] sum, sum_o, diff, diff_o, prod_lo, prod_hi;
    logic [W-1:0] quot, frac, rem;
    logic [W-1:0] shl_res, shl_o, shr_res, shr_o;
    logic         t_eq, t_ne, t_gt, t_any;

    wordalu_op_e  op;
    logic [W-1:0] nx_result, nx_o_val;
    logic         nx_res_we, nx_o_we, nx_cond;

    wordalu_arith #(.W(W)) u_arith (
        .a(in_a), .b(in_b),
        .sum(sum), .sum_o(sum_o), .diff(diff), .diff_o(diff_o),
        .prod_lo(prod_lo), .prod_hi(prod_hi)
    );

    wordalu_divmod #(.W(W)) u_divmod (
        .a(in_a), .b(in_b), .quot(quot), .frac(frac), .rem(rem)
    );

    wordalu_shift #(.W(W)) u_shift (
        .a(in_a), .amt(in_b),
        .shl_res(shl_res), .shl_o(shl_o), .shr_res(shr_res), .shr_o(shr_o)
    );

    wordalu_cmp #(.W(W)) u_cmp (
        .a(in_a), .b(in_b),
        .t_eq(t_eq), .t_ne(t_ne), .t_gt(t_gt), .t_any(t_any)
    );

    // Pick result, overflow value, enables and test flag for the current code.
    always_comb begin
        op        = wordalu_op_e'(in_op);
        nx_result = '0;
        nx_o_val  = '0;
        nx_res_we = 1'b0;
        nx_o_we   = 1'b0;
        nx_cond   = 1'b0;
        unique case (op)
            OP_COPY: begin nx_result = in_b;          nx_res_we = 1'b1; end
            OP_ADD:  begin nx_result = sum;     nx_o_val = sum_o;  nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_SUB:  begin nx_result = diff;    nx_o_val = diff_o; nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_MUL:  begin nx_result = prod_lo; nx_o_val = prod_hi; nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_DIV:  begin nx_result = quot;    nx_o_val = frac;   nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_REM:  begin nx_result = rem;           nx_res_we = 1'b1; end
            OP_SHL:  begin nx_result = shl_res; nx_o_val = shl_o;  nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_SHR:  begin nx_result = shr_res; nx_o_val = shr_o;  nx_res_we = 1'b1; nx_o_we = 1'b1; end
            OP_AND:  begin nx_result = in_a & in_b;   nx_res_we = 1'b1; end
            OP_OR:   begin nx_result = in_a | in_b;   nx_res_we = 1'b1; end
            OP_XOR:  begin nx_result = in_a ^ in_b;   nx_res_we = 1'b1; end
            OP_TEQ:  nx_cond = t_eq;
            OP_TNE:  nx_cond = t_ne;
            OP_TGT:  nx_cond = t_gt;
            OP_TANY: nx_cond = t_any;
            default: nx_cond = 1'b0;
        endcase
    end

    // Output stage: one register level, enables qualified by the valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_res_we <= 1'b0;
            out_o_we   <= 1'b0;
            out_o_val  <= '0;
            out_cond   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_result <= nx_result;
            out_o_val  <= nx_o_val;
            out_res_we <= in_valid & nx_res_we;
            out_o_we   <= in_valid & nx_o_we;
            out_cond   <= in_valid & nx_cond;
        end
    end
endmodule

// File: rtl/wordalu_chk.sv
// Module: property checker for wordalu, attached by the bind at the end.
// Observes ports only; assumes the synchronous active-low reset of the top.
module wordalu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   in_op,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_result,
    input logic         out_res_we,
    input logic         out_o_we,
    input logic [W-1:0] out_o_val,
    input logic         out_cond
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_res_we && !out_o_we && !out_cond));
    a_r4_carry_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'h2) |=> (out_o_we && out_o_val <= 1));
    a_r5_borrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'h3) |=> (out_o_val == '0 || out_o_val == '1));
    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'h5 && in_b == '0) |=> (out_result == '0 && out_o_val == '0));
    a_r8_rem_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'h6 && in_b == '0) |=> (out_result == '0 && !out_o_we));
    a_r9_shift_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'h7 || in_op == 4'h8) && in_b >= 32)
        |=> (out_result == '0 && out_o_val == '0));
    a_r10_logic_keeps_o: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'h1 || in_op == 4'h9 || in_op == 4'hA || in_op == 4'hB))
        |=> (out_res_we && !out_o_we));
    a_r11_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'hC) |=> (!out_res_we && !out_o_we));
    a_r12_cond_only_tests: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op < 4'hC) |=> !out_cond);
    a_r12_none_writes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'h0) |=> (!out_res_we && !out_o_we));
endmodule

bind wordalu wordalu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_res_we(out_res_we), .out_o_we(out_o_we), .out_o_val(out_o_val),
    .out_cond(out_cond)
);

// File: tb/wordalu_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared against the unit on every clock.
module wordalu_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid, out_res_we, out_o_we, out_cond;
    logic [W-1:0] out_result, out_o_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected values for the operation driven in the previous cycle.
    bit      e_valid = 0, e_rwe = 0, e_owe = 0, e_cond = 0;
    longint  e_res = 0, e_o = 0;
    int      e_op = 0;

    always #2.5 clk = ~clk;

    wordalu #(.W(W)) u_wordalu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_res_we(out_res_we), .out_o_we(out_o_we), .out_o_val(out_o_val),
        .out_cond(out_cond)
    );

    function automatic string tag_of(int op);
        case (op)
            0: return "R12";  1: return "R3";  2: return "R4";  3: return "R5";
            4: return "R6";   5: return "R7";  6: return "R8";
            7, 8: return "R9";
            9, 10, 11: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Reference model from the requirements, using wide integers.
    task automatic model(input int op, input longint a, input longint b);
        longint w;
        e_op = op; e_rwe = 0; e_owe = 0; e_cond = 0; e_res = 0; e_o = 0;
        case (op)
            1:  begin e_rwe = 1; e_res = b; end
            2:  begin w = a + b; e_rwe = 1; e_owe = 1; e_res = w & 'hffff; e_o = (w > 'hffff) ? 1 : 0; end
            3:  begin e_rwe = 1; e_owe = 1; e_res = (a - b) & 'hffff; e_o = (b > a) ? 'hffff : 0; end
            4:  begin w = a * b; e_rwe = 1; e_owe = 1; e_res = w & 'hffff; e_o = (w >> 16) & 'hffff; end
            5:  begin e_rwe = 1; e_owe = 1;
                      if (b != 0) begin e_res = a / b; e_o = ((a * 65536) / b) & 'hffff; end end
            6:  begin e_rwe = 1; if (b != 0) e_res = a % b; end
            7:  begin e_rwe = 1; e_owe = 1;
                      if (b < 32) begin w = a << b; e_res = w & 'hffff; e_o = (w >> 16) & 'hffff; end end
            8:  begin e_rwe = 1; e_owe = 1;
                      if (b < 32) begin e_res = a >> b; e_o = ((a * 65536) >> b) & 'hffff; end end
            9:  begin e_rwe = 1; e_res = a & b; end
            10: begin e_rwe = 1; e_res = a | b; end
            11: begin e_rwe = 1; e_res = a ^ b; end
            12: e_cond = (a == b);
            13: e_cond = (a != b);
            14: e_cond = (a > b);
            15: e_cond = ((a & b) != 0);
            default: ;
        endcase
    endtask

    // Compare the unit's outputs with the pending expectation.
    task automatic compare();
        bit bad;
        checks++;
        if (out_valid !== e_valid) begin
            fails++;
            $display("FAIL R2 valid: actual %0b expected %0b", out_valid, e_valid);
            return;
        end
        if (!e_valid) begin
            bad = (out_res_we !== 1'b0) || (out_o_we !== 1'b0) || (out_cond !== 1'b0);
            if (bad) begin
                fails++;
                $display("FAIL R2 idle enables: actual we=%0b owe=%0b cond=%0b expected 0 0 0",
                         out_res_we, out_o_we, out_cond);
            end
            return;
        end
        bad = (out_res_we !== e_rwe) || (out_o_we !== e_owe) || (out_cond !== e_cond) ||
              (e_rwe && (longint'(out_result) != e_res)) || (e_owe && (longint'(out_o_val) != e_o));
        if (bad) begin
            fails++;
            $display("FAIL %s op=%0d: actual res=%h we=%0b o=%h owe=%0b cond=%0b expected res=%h we=%0b o=%h owe=%0b cond=%0b",
                     tag_of(e_op), e_op, out_result, out_res_we, out_o_val, out_o_we, out_cond,
                     e_res[15:0], e_rwe, e_o[15:0], e_owe, e_cond);
        end
    endtask

    // One cycle: check last cycle's operation, then drive the next one.
    task automatic step(input bit v, input int op, input int a, input int b);
        @(negedge clk);
        compare();
        in_valid = v;
        in_op    = 4'(op);
        in_a     = W'(a);
        in_b     = W'(b);
        e_valid  = v;
        if (v) model(op, longint'(in_a), longint'(in_b));
        else begin e_rwe = 0; e_owe = 0; e_cond = 0; end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_res_we !== 1'b0 || out_o_we !== 1'b0 || out_cond !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual v=%0b we=%0b owe=%0b cond=%0b expected 0 0 0 0",
                     out_valid, out_res_we, out_o_we, out_cond);
        end
        rst_n = 1'b1;

        // R3 copy, R4 carry edges
        step(1, 1, 'h1234, 'hbeef);
        step(1, 2, 'hffff, 'h0001);
        step(1, 2, 'h8000, 'h7fff);
        step(0, 2, 'hffff, 'hffff);          // R2 bubble
        // R5 borrow edges
        step(1, 3, 'h0000, 'h0001);
        step(1, 3, 'h0005, 'h0005);
        // R6 products
        step(1, 4, 'hffff, 'hffff);
        step(1, 4, 'h0100, 'h0100);
        // R7 divide incl. zero divisor and fraction
        step(1, 5, 'h1234, 'h0000);
        step(1, 5, 'h0001, 'h0003);
        step(1, 5, 'hffff, 'h0001);
        // R8 remainder
        step(1, 6, 'h0007, 'h0000);
        step(1, 6, 'h0007, 'h0003);
        // R9 shifts around the flush boundary
        step(1, 7, 'h0001, 15);
        step(1, 7, 'hffff, 16);
        step(1, 7, 'hffff, 31);
        step(1, 7, 'hffff, 32);
        step(1, 7, 'hffff, 'hffff);
        step(1, 8, 'h8001, 1);
        step(1, 8, 'hffff, 16);
        step(1, 8, 'hffff, 31);
        step(1, 8, 'hffff, 32);
        // R10 logic
        step(1, 9,  'hf0f0, 'h3c3c);
        step(1, 10, 'hf0f0, 'h3c3c);
        step(1, 11, 'hf0f0, 'h3c3c);
        // R11 tests, true and false
        step(1, 12, 'h00aa, 'h00aa);
        step(1, 12, 'h00aa, 'h00ab);
        step(1, 13, 'h00aa, 'h00aa);
        step(1, 14, 'h8000, 'h7fff);
        step(1, 14, 'h7fff, 'h8000);
        step(1, 15, 'h0f00, 'h00f0);
        step(1, 15, 'h0f00, 'h0100);
        // R12 no operation
        step(1, 0, 'hffff, 'hffff);

        // Random sweep over all codes, with occasional idle cycles (R2)
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) != 0, i % 16, int'($urandom & 'hffff),
                 ((i & 3) == 0) ? int'($urandom % 40) : int'($urandom & 'hffff));
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule